// File: doc/BRIEF.md
# Powerdown Wake Sequencer

This block manages the return of a processor core from a deep sleep state in which every internal clock is stopped. Software sets a powerdown control bit. A halt-entry strobe then moves the sequencer into sleep. In sleep the oscillator enable and the internal clock gate are both dropped. The block runs on a free-running slow clock that keeps running during sleep, so wake requests are seen without the gated core clock.

A non-maskable interrupt or an unmasked maskable interrupt restarts the oscillator at once. The block then waits out a stabilization delay, modelled as a down-counter loaded from a programmable value at the start of the wake. When the counter reaches zero it signals oscillator-ready. After that it lets one more cycle pass and then re-opens the internal clock gate. Last, it issues two timed single-cycle strobes: one for the request reaching the CPU and one for the vector fetch or acknowledge cycle.

An interrupt wake leaves the powerdown bit set. A reset wake request takes priority over everything else. It clears the bit, returns the sequencer to the running state along the cold-start path, and cancels any delivery still in flight.

Top module: `pdw_wake_seq`

## Requirements
- R1: After the block reset (rst_n low), the sequencer is running: clock_gate_en=1, osc_en=1, pd_bit=0, and both strobes are 0.
- R2: A pd_set pulse sets pd_bit and a pd_clr pulse clears it; clear wins if both are high. A halt_strobe moves the block into sleep only when pd_bit is 1. A halt_strobe with pd_bit=0 has no effect.
- R3: In sleep, clock_gate_en=0 and osc_en=0.
- R4: In sleep, nmi_req=1 or irq_req=1 at a clock edge starts a wake, and osc_en reads 1 right after that edge. The stabilization counter takes the value of stab_load sampled at that edge.
- R5: clock_gate_en rises exactly L+2 clock edges after the wake edge, where L is the loaded value. Oscillator-ready holds at edge L, and one further full cycle follows before the gate opens.
- R6: A wake by nmi_req or irq_req leaves pd_bit at 1.
- R7: For a wake by nmi_req, cpu_irq_strobe is high in the cycle 2 edges after the gate opens. vector_cycle_strobe is high 6 edges after that. The block is running again (gate and oscillator enabled, no strobe) one edge after the vector strobe.
- R8: For a wake by irq_req, no strobe appears until irq_resolved is sampled high after the gate opens. cpu_irq_strobe follows 2 edges after that sample, and vector_cycle_strobe 6 edges after the CPU strobe. An irq_resolved pulse seen before the gate opens is ignored.
- R9: wake_rst has priority over every other input. The edge after it has been sampled shows the running state with gate and oscillator enabled, pd_bit=0, and no strobe. No strobe from the cancelled wake appears later.
- R10: While the block is running, nmi_req, irq_req and irq_resolved produce no strobe and leave clock_gate_en and osc_en at 1.
- R11: Each strobe is high for exactly one cycle per wake.
- R12: A change of stab_load after the wake edge does not change the wake latency of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow clock, active during sleep |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wake_rst | input | 1 | Synchronous reset wake request, highest priority |
| pd_set | input | 1 | Pulse that sets the powerdown control bit |
| pd_clr | input | 1 | Pulse that clears the powerdown control bit |
| halt_strobe | input | 1 | Halt-entry strobe from the core |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Unmasked maskable interrupt request |
| irq_resolved | input | 1 | Interrupt controller finished priority resolution |
| stab_load | input | CNT_W | Stabilization delay load value, in clock cycles |
| pd_bit | output | 1 | Current powerdown control bit |
| clock_gate_en | output | 1 | Enable of the internal clock gate |
| osc_en | output | 1 | Oscillator enable |
| cpu_irq_strobe | output | 1 | One-cycle pulse: the request reaches the CPU |
| vector_cycle_strobe | output | 1 | One-cycle pulse: the vector fetch or acknowledge cycle starts |

## Verification
The assertions assume that all inputs are synchronous to clk and that irq_resolved only means something once the gate has re-opened. They also assume that a wake source is dropped once the sequencer has left sleep. The bench drives every input on the falling edge and releases each wake source right after the wake edge. It pulses irq_resolved once before the gate opens, to show that the early pulse is ignored, and once at a chosen delay afterwards. The bench sweeps stab_load over a range of small values for both interrupt sources. Reset wakes are aimed at sleep, at the settling wait and at mid-delivery.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_SLEEP      = 3'd1,
    ST_OSC_SETTLE = 3'd2,
    ST_CLK_GRACE  = 3'd3,
    ST_DELIVER    = 3'd4
  } pdw_state_e;

  // Edges from the wake edge until the internal clock gate opens:
  // the load value, one edge out of settling, one grace edge.
  function automatic int unsigned gate_latency(input int unsigned load);
    return load + 2;
  endfunction

  // Total delivery length in edges from the start point to the vector strobe.
  function automatic int unsigned deliver_span(input int unsigned cpu_dly,
                                               input int unsigned vec_dly);
    return cpu_dly + vec_dly;
  endfunction

  // Bits needed to hold a count of 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pdw_ctl_bit.sv
module pdw_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_q
);

  logic bit_d;

  always_comb begin
    bit_d = bit_q;
    if (set_i) bit_d = 1'b1;
    if (clr_i || wake_rst) bit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  // R9: a reset wake always leaves the control bit cleared
  assert_rst_clears_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> !bit_q);

endmodule

// File: rtl/pdw_settle_timer.sv
module pdw_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             osc_ok_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= load_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign osc_ok_o = run_i && (cnt_q == '0);

  // R12: once running, the count never goes up, whatever the load input does
  assert_no_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && $past(run_i) |-> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/pdw_deliver_timer.sv
module pdw_deliver_timer #(
  parameter int unsigned CPU_DLY = 2,
  parameter int unsigned VEC_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  output logic go_o,
  output logic cpu_hit_o,
  output logic vec_hit_o
);
  import pdw_pkg::*;

  localparam int unsigned SPAN = deliver_span(CPU_DLY, VEC_DLY);
  localparam int unsigned DW   = cnt_bits(SPAN);
  localparam logic [DW-1:0] CPU_AT = DW'(CPU_DLY);
  localparam logic [DW-1:0] VEC_AT = DW'(SPAN);

  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_o   <= 1'b0;
      dcnt_q <= '0;
    end else if (clr_i || vec_hit_o) begin
      go_o   <= 1'b0;
      dcnt_q <= '0;
    end else if (start_i) begin
      go_o   <= 1'b1;
      dcnt_q <= '0;
    end else if (go_o) begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign cpu_hit_o = go_o && (dcnt_q == CPU_AT);
  assign vec_hit_o = go_o && (dcnt_q == VEC_AT);

  // R11: each hit lasts one cycle
  assert_cpu_hit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit_o |=> !cpu_hit_o);
  assert_vec_hit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit_o |=> !vec_hit_o);

endmodule

// File: rtl/pdw_wake_seq.sv
module pdw_wake_seq #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CPU_DLY = 2,
  parameter int unsigned VEC_DLY = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_rst,
  input  logic             pd_set,
  input  logic             pd_clr,
  input  logic             halt_strobe,
  input  logic             nmi_req,
  input  logic             irq_req,
  input  logic             irq_resolved,
  input  logic [CNT_W-1:0] stab_load,
  output logic             pd_bit,
  output logic             clock_gate_en,
  output logic             osc_en,
  output logic             cpu_irq_strobe,
  output logic             vector_cycle_strobe
);
  import pdw_pkg::*;

  pdw_state_e       state_q, state_d;
  logic             nmi_src_q;
  logic             wake_any;
  logic             wake_take;
  logic             settle_run;
  logic             osc_ok;
  logic [CNT_W-1:0] settle_cnt;
  logic             dlv_clr, dlv_start, dlv_go, cpu_hit, vec_hit;
  logic             in_deliver;

  pdw_ctl_bit u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_rst (wake_rst),
    .set_i    (pd_set),
    .clr_i    (pd_clr),
    .bit_q    (pd_bit)
  );

  assign settle_run = (state_q == ST_OSC_SETTLE) && !wake_rst;

  pdw_settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (settle_run),
    .load_i   (stab_load),
    .cnt_q    (settle_cnt),
    .osc_ok_o (osc_ok)
  );

  assign in_deliver = (state_q == ST_DELIVER);
  assign dlv_clr    = wake_rst || !(in_deliver || state_q == ST_CLK_GRACE);
  assign dlv_start  = (state_q == ST_CLK_GRACE && nmi_src_q) ||
                      (in_deliver && !nmi_src_q && !dlv_go && irq_resolved);

  pdw_deliver_timer #(.CPU_DLY(CPU_DLY), .VEC_DLY(VEC_DLY)) u_dlv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (dlv_clr),
    .start_i   (dlv_start),
    .go_o      (dlv_go),
    .cpu_hit_o (cpu_hit),
    .vec_hit_o (vec_hit)
  );

  assign wake_any  = nmi_req || irq_req;
  assign wake_take = (state_q == ST_SLEEP) && wake_any && !wake_rst;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:        if (pd_bit && halt_strobe) state_d = ST_SLEEP;
      ST_SLEEP:      if (wake_any)              state_d = ST_OSC_SETTLE;
      ST_OSC_SETTLE: if (osc_ok)                state_d = ST_CLK_GRACE;
      ST_CLK_GRACE:                             state_d = ST_DELIVER;
      ST_DELIVER:    if (vec_hit)               state_d = ST_RUN;
      default:                                  state_d = ST_RUN;
    endcase
    if (wake_rst) state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      nmi_src_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wake_take) nmi_src_q <= nmi_req;
    end
  end

  assign osc_en              = (state_q != ST_SLEEP);
  assign clock_gate_en       = (state_q == ST_RUN) || in_deliver;
  assign cpu_irq_strobe      = in_deliver && cpu_hit;
  assign vector_cycle_strobe = in_deliver && vec_hit;

  // R5: the gate only opens two edges after oscillator-ready, unless a reset wake did it
  assert_gate_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clock_gate_en) && !$past(wake_rst) && $past(state_q == ST_CLK_GRACE)
      |-> $past(osc_ok, 2));

  // R6: an interrupt wake keeps the powerdown bit
  assert_wake_keeps_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take && !pd_clr |=> pd_bit);

  // R9: reset wake wins over everything
  assert_rst_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> clock_gate_en && osc_en && !cpu_irq_strobe && !vector_cycle_strobe);

  // R3: sleep means oscillator off and gate closed
  assert_sleep_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !clock_gate_en && !cpu_irq_strobe);

  // R11: the vector strobe never shares a cycle with the CPU strobe
  assert_strobes_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_irq_strobe && vector_cycle_strobe));

endmodule

// File: tb/sim_pdw_wake_seq.sv
`timescale 1ns/1ps
module sim_pdw_wake_seq;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_rst = 0, pd_set = 0, pd_clr = 0, halt_strobe = 0;
  logic nmi_req = 0, irq_req = 0, irq_resolved = 0;
  logic [CNT_W-1:0] stab_load = '0;
  logic pd_bit, clock_gate_en, osc_en, cpu_irq_strobe, vector_cycle_strobe;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pdw_wake_seq #(.CNT_W(CNT_W), .CPU_DLY(2), .VEC_DLY(6)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_rst(wake_rst), .pd_set(pd_set),
    .pd_clr(pd_clr), .halt_strobe(halt_strobe), .nmi_req(nmi_req),
    .irq_req(irq_req), .irq_resolved(irq_resolved), .stab_load(stab_load),
    .pd_bit(pd_bit), .clock_gate_en(clock_gate_en), .osc_en(osc_en),
    .cpu_irq_strobe(cpu_irq_strobe), .vector_cycle_strobe(vector_cycle_strobe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic sel_sig(input int sel);
    case (sel)
      0:       return clock_gate_en;
      1:       return cpu_irq_strobe;
      default: return vector_cycle_strobe;
    endcase
  endfunction

  // counts edges until the selected output is seen high at a falling edge
  task automatic edges_until(input int sel, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!sel_sig(sel) && n < limit);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic enter_sleep();
    pd_set = 1; step(); pd_set = 0;
    halt_strobe = 1; step(); halt_strobe = 0;
  endtask

  // wake from sleep with load L; src 1=NMI, 0=maskable; rdel = edges before resolution
  task automatic wake_run(input int L, input bit src, input int rdel);
    int n, cpu_seen, exp_gate;
    enter_sleep();
    chk("R3", "gate in sleep", clock_gate_en, 0);
    chk("R3", "osc in sleep", osc_en, 0);
    stab_load = CNT_W'(L);
    if (src) nmi_req = 1; else irq_req = 1;
    @(posedge clk); @(negedge clk);            // wake edge passed
    nmi_req = 0; irq_req = 0;
    chk("R4", "osc after wake", osc_en, 1);
    stab_load = CNT_W'(L + 5);                 // R12: late change must not matter
    if (!src) irq_resolved = 1;                // R8: early resolution is ignored
    edges_until(0, 400, n);
    irq_resolved = 0;
    exp_gate = L + 2;
    chk(src ? "R5" : "R12", "edges to gate open", n, exp_gate);
    chk("R6", "pd_bit after wake", pd_bit, 1);
    if (!src) begin
      for (int i = 0; i < rdel + 4; i++) begin
        chk("R8", "no strobe before resolve", cpu_irq_strobe, 0);
        @(negedge clk);
      end
      irq_resolved = 1;
      @(posedge clk); @(negedge clk);
      irq_resolved = 0;
    end
    edges_until(1, 40, n);
    chk(src ? "R7" : "R8", "edges to cpu strobe", n, 2);
    n = 0; cpu_seen = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
      if (cpu_irq_strobe) cpu_seen++;
    end while (!vector_cycle_strobe && n < 40);
    chk(src ? "R7" : "R8", "edges to vector strobe", n, 6);
    chk("R11", "cpu strobe width", cpu_seen, 0);
    step();
    chk("R11", "vector strobe width", vector_cycle_strobe, 0);
    chk("R7", "running gate", clock_gate_en, 1);
    chk("R7", "running osc", osc_en, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "gate at reset", clock_gate_en, 1);
    chk("R1", "osc at reset", osc_en, 1);
    chk("R1", "pd_bit at reset", pd_bit, 0);
    chk("R1", "strobes at reset", cpu_irq_strobe | vector_cycle_strobe, 0);

    // R2: halt without the bit is ignored; set/clear behaviour
    halt_strobe = 1; step(); halt_strobe = 0; step();
    chk("R2", "halt without bit keeps gate", clock_gate_en, 1);
    pd_set = 1; pd_clr = 1; step(); pd_set = 0; pd_clr = 0;
    chk("R2", "clear wins", pd_bit, 0);
    pd_set = 1; step(); pd_set = 0;
    chk("R2", "set", pd_bit, 1);
    pd_clr = 1; step(); pd_clr = 0;
    chk("R2", "clear", pd_bit, 0);

    // R10: interrupts while running do nothing here
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      nmi_req = i[0]; irq_req = i[1]; irq_resolved = i[2];
      step();
      if (cpu_irq_strobe || vector_cycle_strobe || !clock_gate_en || !osc_en) hits++;
    end
    nmi_req = 0; irq_req = 0; irq_resolved = 0;
    step(); step();
    chk("R10", "running-state disturbance", hits, 0);

    // main sweep over load values and both sources
    for (int L = 0; L < 16; L++) begin
      wake_run(L, 1'b1, 0);
      wake_run(L, 1'b0, 1 + (L % 3));
    end

    // R9: reset wake from sleep
    enter_sleep();
    wake_rst = 1; step(); wake_rst = 0;
    chk("R9", "gate after reset wake in sleep", clock_gate_en, 1);
    chk("R9", "osc after reset wake in sleep", osc_en, 1);
    chk("R9", "pd_bit after reset wake", pd_bit, 0);

    // R9: reset wake during settling
    enter_sleep();
    stab_load = 8'd10; nmi_req = 1; step(); nmi_req = 0;
    step(); step();
    wake_rst = 1; step(); wake_rst = 0;
    chk("R9", "gate after reset in settle", clock_gate_en, 1);
    chk("R9", "pd_bit after reset in settle", pd_bit, 0);
    hits = 0;
    for (int i = 0; i < 25; i++) begin
      if (cpu_irq_strobe || vector_cycle_strobe) hits++;
      step();
    end
    chk("R9", "strobes after settle reset", hits, 0);

    // R9: reset wake mid delivery, after the CPU strobe
    enter_sleep();
    stab_load = 8'd1; nmi_req = 1; step(); nmi_req = 0;
    edges_until(1, 40, hits);
    chk("R7", "cpu strobe before cancel", cpu_irq_strobe, 1);
    step();
    wake_rst = 1; step(); wake_rst = 0;
    chk("R9", "pd_bit after reset in delivery", pd_bit, 0);
    hits = 0;
    for (int i = 0; i < 15; i++) begin
      if (cpu_irq_strobe || vector_cycle_strobe || !clock_gate_en) hits++;
      step();
    end
    chk("R9", "vector suppressed", hits, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule